// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the memory side of one bank of a 16-bit synchronous DRAM. It accepts column READ and WRITE commands and runs a fixed burst of four words against an internal word array. Write words are taken from a data input bus. Read words are returned on a data output bus with an output enable, after a CAS latency of two or three cycles.

A clock-enable input is sampled on every rising edge of the clock. A low sample taken while a burst is running suspends the next internal edge. On a suspended edge the sequencer does not advance: the burst counter and the latency count hold, commands and write data are dropped, and the read word on the output stays driven. The real clock is never gated. Suspension only sets an internal run enable for the registers.

Top module: `sdram_burst_engine`

## Requirements
- R1: A WRITE command (cmd_i = 2'b10) accepted while idle stores dq_i at column col_i on the accepting edge. It then stores three more words on the following non-suspended edges. The column is the start column with its two low bits incremented modulo 4, so the burst wraps inside the aligned four-word block.
- R2: A READ command (cmd_i = 2'b01) accepted while idle returns four words in the same wrapped column order. The first word appears on dq_o after CAS_LAT-1 non-suspended edges following the accepting edge. Each later word appears one non-suspended edge after the previous one.
- R3: dq_oe_o is high from the first read word through the last read word and low at all other times. busy_o is high from the accepting edge until the edge that retires the burst's last word.
- R4: When cke_i is sampled low on an edge while busy_o is high, the next edge is suspended. On that edge dq_o, dq_oe_o, busy_o and the burst position keep their values.
- R5: Write data present on dq_i at a suspended edge is not stored, and the burst's next word goes to the column that would have been written.
- R6: A low cke_i sample taken while idle suspends nothing. A command on the next edge is accepted normally.
- R7: While busy_o is high, any command other than NOP (2'b00) is ignored. The reserved code 2'b11 behaves as NOP while idle.
- R8: The read latency counts only non-suspended edges, so a suspension before the first read word delays that word by one cycle per suspended edge.
- R9: An active-low asynchronous reset sets busy_o and dq_oe_o low and dq_o to zero at once. It leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable, sampled each rising edge |
| cmd_i | input | 2 | Command: 00 NOP, 01 READ, 10 WRITE, 11 reserved (NOP) |
| col_i | input | 9 | Starting column of a burst |
| dq_i | input | 16 | Write data |
| dq_o | output | 16 | Read data |
| dq_oe_o | output | 1 | Read data output enable |
| busy_o | output | 1 | Burst in progress |

## Verification
The checker assumes that cmd_i, col_i, dq_i and cke_i are known at every rising edge after reset. It also assumes CAS_LAT is at least 2, so no read word can appear on the edge that accepts the command. The bench drives all inputs on the falling edge from a vector table and holds them at defined values throughout, including during reset. Every read burst targets columns that an earlier write burst filled, so no undefined word ever reaches dq_o.

// File: rtl/sbe_pkg.sv
`timescale 1ns/1ps
package sbe_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } sbe_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_RD_WAIT = 2'b01,
    PH_RD_DATA = 2'b10,
    PH_WR      = 2'b11
  } sbe_phase_e;

endpackage

// File: rtl/sbe_suspend_ctl.sv
`timescale 1ns/1ps
// Registers the clock-enable sample and forms the internal run enable.
// An edge is suspended only when the previous sample was low and a burst
// is in progress.
module sbe_suspend_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_i,
  input  logic busy_i,
  output logic run_o
);

  logic cke_q;
  logic cke_d;

  always_comb begin
    cke_d = cke_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q <= 1'b1;
    end else begin
      cke_q <= cke_d;
    end
  end

  assign run_o = cke_q | ~busy_i;

endmodule

// File: rtl/sbe_burst_seq.sv
`timescale 1ns/1ps
// Burst sequencer: accepts commands while idle, counts CAS latency and
// burst beats on non-suspended edges, produces array access strobes.
module sbe_burst_seq
  import sbe_pkg::*;
#(
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 4,   // power of two, at least 2
  parameter int CAS_LAT   = 2    // 2 or 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [1:0]       cmd_i,
  input  logic [COL_W-1:0] col_i,
  output logic             busy_o,
  output logic             wr_en_o,
  output logic [COL_W-1:0] wr_addr_o,
  output logic             rd_load_o,
  output logic [COL_W-1:0] rd_addr_o,
  output logic             rd_end_o
);

  localparam int BEAT_W = $clog2(BURST_LEN);
  localparam int LAT_W  = $clog2(CAS_LAT + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);
  localparam logic [LAT_W-1:0]  LAT_INIT  = LAT_W'(CAS_LAT - 1);
  localparam logic [LAT_W-1:0]  LAT_ONE   = LAT_W'(1);

  sbe_phase_e        phase_q, phase_d;
  logic [COL_W-1:0]  base_q,  base_d;
  logic [BEAT_W-1:0] beat_q,  beat_d;
  logic [LAT_W-1:0]  lat_q,   lat_d;

  sbe_cmd_e          cmd;
  logic              idle;
  logic              acc_rd;
  logic              acc_wr;
  logic [BEAT_W-1:0] rd_beat;

  function automatic logic [COL_W-1:0] wrap_col(
    input logic [COL_W-1:0]  base,
    input logic [BEAT_W-1:0] off
  );
    logic [BEAT_W-1:0] lo;
    lo = base[BEAT_W-1:0] + off;
    return {base[COL_W-1:BEAT_W], lo};
  endfunction

  assign cmd    = sbe_cmd_e'(cmd_i);
  assign idle   = (phase_q == PH_IDLE);
  assign acc_rd = run_i && idle && (cmd == CMD_READ);
  assign acc_wr = run_i && idle && (cmd == CMD_WRITE);

  // array write strobe and column
  always_comb begin
    wr_en_o   = acc_wr || (run_i && (phase_q == PH_WR));
    wr_addr_o = acc_wr ? col_i : wrap_col(base_q, beat_q);
  end

  // output register load strobes
  always_comb begin
    rd_beat   = (phase_q == PH_RD_DATA) ? (beat_q + BEAT_W'(1)) : '0;
    rd_addr_o = wrap_col(base_q, rd_beat);
    rd_load_o = run_i &&
                (((phase_q == PH_RD_WAIT) && (lat_q == LAT_ONE)) ||
                 ((phase_q == PH_RD_DATA) && (beat_q != LAST_BEAT)));
    rd_end_o  = run_i && (phase_q == PH_RD_DATA) && (beat_q == LAST_BEAT);
  end

  // next state
  always_comb begin
    phase_d = phase_q;
    base_d  = base_q;
    beat_d  = beat_q;
    lat_d   = lat_q;
    if (run_i) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (cmd == CMD_READ) begin
            phase_d = PH_RD_WAIT;
            base_d  = col_i;
            beat_d  = '0;
            lat_d   = LAT_INIT;
          end else if (cmd == CMD_WRITE) begin
            phase_d = PH_WR;
            base_d  = col_i;
            beat_d  = BEAT_W'(1);
          end
        end
        PH_RD_WAIT: begin
          if (lat_q == LAT_ONE) begin
            phase_d = PH_RD_DATA;
            beat_d  = '0;
          end else begin
            lat_d = lat_q - LAT_ONE;
          end
        end
        PH_RD_DATA: begin
          if (beat_q == LAST_BEAT) begin
            phase_d = PH_IDLE;
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
        PH_WR: begin
          if (beat_q == LAST_BEAT) begin
            phase_d = PH_IDLE;
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      base_q  <= '0;
      beat_q  <= '0;
      lat_q   <= '0;
    end else begin
      phase_q <= phase_d;
      base_q  <= base_d;
      beat_q  <= beat_d;
      lat_q   <= lat_d;
    end
  end

  assign busy_o = ~idle;

endmodule

// File: rtl/sbe_word_store.sv
`timescale 1ns/1ps
// Column word array: one synchronous write port, one combinational read port.
module sbe_word_store #(
  parameter int COL_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [COL_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [COL_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/sbe_dq_drive.sv
`timescale 1ns/1ps
// Read data output register and output enable; holds while not loaded.
module sbe_dq_drive #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              end_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              oe_o
);

  logic [DATA_W-1:0] dq_q, dq_d;
  logic              oe_q, oe_d;

  always_comb begin
    dq_d = dq_q;
    oe_d = oe_q;
    if (load_i) begin
      dq_d = rdata_i;
      oe_d = 1'b1;
    end else if (end_i) begin
      oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
      oe_q <= 1'b0;
    end else begin
      dq_q <= dq_d;
      oe_q <= oe_d;
    end
  end

  assign dq_o = dq_q;
  assign oe_o = oe_q;

endmodule

// File: rtl/sdram_burst_engine.sv
`timescale 1ns/1ps
module sdram_burst_engine #(
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_i,
  input  logic [1:0]        cmd_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              busy_o
);

  logic              run;
  logic              wr_en;
  logic [COL_W-1:0]  wr_addr;
  logic              rd_load;
  logic [COL_W-1:0]  rd_addr;
  logic              rd_end;
  logic [DATA_W-1:0] rd_word;

  sbe_suspend_ctl u_susp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke_i  (cke_i),
    .busy_i (busy_o),
    .run_o  (run)
  );

  sbe_burst_seq #(
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN),
    .CAS_LAT   (CAS_LAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .cmd_i     (cmd_i),
    .col_i     (col_i),
    .busy_o    (busy_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_load_o (rd_load),
    .rd_addr_o (rd_addr),
    .rd_end_o  (rd_end)
  );

  sbe_word_store #(
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (dq_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_word)
  );

  sbe_dq_drive #(
    .DATA_W (DATA_W)
  ) u_dq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (rd_load),
    .end_i   (rd_end),
    .rdata_i (rd_word),
    .dq_o    (dq_o),
    .oe_o    (dq_oe_o)
  );

endmodule

// File: rtl/sbe_checker.sv
`timescale 1ns/1ps
module sbe_checker #(
  parameter int COL_W  = 9,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_i,
  input logic [1:0]        cmd_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic              busy_o
);

  logic cke_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev <= 1'b1;
    end else begin
      cke_prev <= cke_i;
    end
  end

  AST_OE_WITHIN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> busy_o); // R3

  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cke_prev) |=> ($stable(dq_o) && $stable(dq_oe_o) && $stable(busy_o))); // R4

  AST_READ_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_i == 2'b01) |=> (busy_o && !dq_oe_o)); // R2

  AST_WRITE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_i == 2'b10) |=> (busy_o && !dq_oe_o)); // R1

  AST_IDLE_NOP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (cmd_i == 2'b00 || cmd_i == 2'b11)) |=> !busy_o); // R7

endmodule

bind sdram_burst_engine sbe_checker #(
  .COL_W  (COL_W),
  .DATA_W (DATA_W)
) u_sbe_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .cke_i   (cke_i),
  .cmd_i   (cmd_i),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o),
  .busy_o  (busy_o)
);

// File: tb/sdram_burst_engine_bench.sv
`timescale 1ns/1ps
module sdram_burst_engine_bench;

  logic        clk;
  logic        rst_n;
  logic        cke_i;
  logic [1:0]  cmd_i;
  logic [8:0]  col_i;
  logic [15:0] dq_i;
  logic [15:0] dq_o;
  logic        dq_oe_o;
  logic        busy_o;

  int checks;
  int failures;

  sdram_burst_engine u_sdram_burst_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_i   (cke_i),
    .cmd_i   (cmd_i),
    .col_i   (col_i),
    .dq_i    (dq_i),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o),
    .busy_o  (busy_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // inputs applied before an edge, outputs expected after it
  typedef struct packed {
    logic        cke;
    logic [1:0]  cmd;
    logic [8:0]  col;
    logic [15:0] din;
    logic        e_busy;
    logic        e_oe;
    logic        chk_dq;
    logic [15:0] e_dq;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VECS [NV] = '{
    // R1 write burst at 0x010
    '{1'b1, 2'd2, 9'h010, 16'hA000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'hA001, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'hA002, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'hA003, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3},
    // R1 write burst starting mid-block at 0x026 (wraps)
    '{1'b1, 2'd2, 9'h026, 16'hB000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'hB001, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'hB002, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'hB003, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3},
    // R2 read 0x010, latency 2
    '{1'b1, 2'd1, 9'h010, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd2},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA000, 4'd2},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA001, 4'd2},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA002, 4'd2},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA003, 4'd2},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3},
    // R4 read 0x027 with one suspended edge and an R7 illegal command
    '{1'b1, 2'd1, 9'h027, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd2},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hB001, 4'd1},
    '{1'b0, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hB002, 4'd1},
    '{1'b1, 2'd2, 9'h000, 16'hFFFF, 1'b1, 1'b1, 1'b1, 16'hB002, 4'd4},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hB003, 4'd4},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hB000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3},
    // R5 write 0x040 with a suspended edge carrying junk data
    '{1'b1, 2'd2, 9'h040, 16'hC000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},
    '{1'b0, 2'd0, 9'h000, 16'hC001, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'hDEAD, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd5},
    '{1'b1, 2'd0, 9'h000, 16'hC002, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd5},
    '{1'b1, 2'd0, 9'h000, 16'hC003, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd1},
    // R6 cke low while idle, then READ accepted at once
    '{1'b0, 2'd0, 9'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd6},
    '{1'b1, 2'd1, 9'h040, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd6},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hC000, 4'd2},
    '{1'b0, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hC001, 4'd2},
    '{1'b0, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hC001, 4'd4},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hC001, 4'd4},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hC002, 4'd5},
    '{1'b1, 2'd1, 9'h010, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hC003, 4'd7},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3},
    // R7 reserved code while idle
    '{1'b1, 2'd3, 9'h010, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd7},
    // R8 suspension inside the latency window, read 0x024
    '{1'b0, 2'd1, 9'h024, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd8},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd8},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hB002, 4'd8},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hB003, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hB000, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hB001, 4'd1},
    '{1'b1, 2'd0, 9'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3}
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic cke, input logic [1:0] cmd,
                       input logic [8:0] col, input logic [15:0] din);
    cke_i = cke;
    cmd_i = cmd;
    col_i = col;
    dq_i  = din;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    drive(1'b1, 2'd0, 9'h000, 16'h0000);
    #1;
    // R9 asynchronous reset state before any edge
    check(busy_o == 1'b0, "R9", "busy in reset", {15'd0, busy_o}, 16'h0000);
    check(dq_oe_o == 1'b0, "R9", "oe in reset", {15'd0, dq_oe_o}, 16'h0000);
    check(dq_o == 16'h0000, "R9", "dq in reset", dq_o, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cke, VECS[i].cmd, VECS[i].col, VECS[i].din);
      @(negedge clk);
      check(busy_o == VECS[i].e_busy, $sformatf("R%0d v%0d", VECS[i].rq, i),
            "busy", {15'd0, busy_o}, {15'd0, VECS[i].e_busy});
      check(dq_oe_o == VECS[i].e_oe, $sformatf("R%0d v%0d", VECS[i].rq, i),
            "oe", {15'd0, dq_oe_o}, {15'd0, VECS[i].e_oe});
      if (VECS[i].chk_dq) begin
        check(dq_o === VECS[i].e_dq, $sformatf("R%0d v%0d", VECS[i].rq, i),
              "dq", dq_o, VECS[i].e_dq);
      end
    end

    // R9 reset in the middle of a read burst
    drive(1'b1, 2'd1, 9'h010, 16'h0000);
    @(negedge clk);
    drive(1'b1, 2'd0, 9'h000, 16'h0000);
    @(negedge clk);
    check(dq_o === 16'hA000, "R2", "dq before reset", dq_o, 16'hA000);
    #1 rst_n = 1'b0;
    #1;
    check(busy_o == 1'b0, "R9", "busy after mid reset", {15'd0, busy_o}, 16'h0000);
    check(dq_oe_o == 1'b0, "R9", "oe after mid reset", {15'd0, dq_oe_o}, 16'h0000);
    check(dq_o == 16'h0000, "R9", "dq after mid reset", dq_o, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 stored words survive reset
    drive(1'b1, 2'd1, 9'h026, 16'h0000);
    @(negedge clk);
    drive(1'b1, 2'd0, 9'h000, 16'h0000);
    @(negedge clk);
    check(dq_o === 16'hB000, "R9", "word kept over reset", dq_o, 16'hB000);
    check(dq_oe_o == 1'b1, "R3", "oe on first word", {15'd0, dq_oe_o}, 16'h0001);
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R3", "busy after burst", {15'd0, busy_o}, 16'h0000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule